// File: doc/BRIEF.md
# Host Interrupt Cause, Mask and Pin Steering

This block collects two interrupt causes inside a storage controller and presents them to the host through a small register window. One cause is a level. It is high whenever the reply queue holds at least one entry. The other cause is an event. It is captured when the local processor writes the doorbell, and it stays captured until the host clears it.

A read/write mask register holds one mask bit per cause and a two-bit steering field. The unmasked causes are combined, and the result drives one of two active-high interrupt request outputs. It drives neither output when the host has switched to message-signalled interrupts.

Host accesses use a one-bit register select, a write strobe and a 32-bit write data bus. Read data is combinational from the select.

Top module: `host_irq_ctrl`

## Requirements
- R1: Status bit 3 (reply cause) reads 1 exactly while `queue_empty` is low. It tracks the level in both directions and is never latched.
- R2: A cycle with `db_write` high sets status bit 0 (doorbell cause) at the next clock edge. The bit then holds until it is cleared.
- R3: Any write with `reg_sel`=0 clears status bit 0. The value on `reg_wdata` has no effect.
- R4: If `db_write` and a status write occur in the same cycle, status bit 0 ends up set.
- R5: An interrupt is pending only while a status bit is 1 and its mask bit is 0. Mask bit 3 gates the reply cause and mask bit 0 gates the doorbell cause.
- R6: Steering field bits [9:8] of the mask register select the output. 00 drives `irq_pri`, 01 drives `irq_alt`, and 10 or 11 drives neither. The two outputs are never high together.
- R7: While `msi_en` is high, both outputs are low one cycle later, whatever the status and mask values are.
- R8: After reset the mask register reads 0x0000_0009 (both causes masked, steering 00). No output asserts until software clears a mask bit.
- R9: Only mask bits 9, 8, 3 and 0 are writable. All other mask bits read 0 and ignore writes. Status bits other than 3 and 0 read 0.
- R10: The outputs are registered. They reflect the pending and steering state sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 status, 1 mask |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| queue_empty | input | 1 | Reply queue empty flag |
| db_write | input | 1 | Local processor doorbell write strobe, one cycle per event |
| msi_en | input | 1 | Host has enabled message-signalled interrupts |
| irq_pri | output | 1 | Primary interrupt request, active high |
| irq_alt | output | 1 | Alternate interrupt request, active high |

## Verification
The properties assume the following about the inputs:
- All inputs are synchronous to `clk` and stable around the rising edge.
- `reg_sel` and `reg_wdata` matter only in a cycle with `reg_wr` high.
- Reset is applied before the first check.

The stimulus changes every input on the falling edge and holds each strobe for exactly one cycle. Every input is therefore sampled cleanly by the block. Collisions, such as a doorbell strobe in the same cycle as a status write, are created on purpose on a single edge, never by skew.

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl #(
  parameter int DW        = 32,
  parameter int REPLY_BIT = 3,
  parameter int DB_BIT    = 0,
  parameter int ROUTE_LSB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          queue_empty,
  input  logic          db_write,
  input  logic          msi_en,
  output logic          irq_pri,
  output logic          irq_alt
);

  localparam logic [1:0] ROUTE_PRI = 2'b00;
  localparam logic [1:0] ROUTE_ALT = 2'b01;

  logic       db_st;
  logic       msk_reply, msk_db;
  logic [1:0] route;
  logic       pend;

  wire st_wr = reg_wr && !reg_sel;
  wire mk_wr = reg_wr &&  reg_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         db_st <= 1'b0;
    else if (db_write)  db_st <= 1'b1;
    else if (st_wr)     db_st <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      msk_reply <= 1'b1;
      msk_db    <= 1'b1;
      route     <= ROUTE_PRI;
    end else if (mk_wr) begin
      msk_reply <= reg_wdata[REPLY_BIT];
      msk_db    <= reg_wdata[DB_BIT];
      route     <= reg_wdata[ROUTE_LSB +: 2];
    end

  assign pend = (!queue_empty && !msk_reply) || (db_st && !msk_db);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_pri <= 1'b0;
      irq_alt <= 1'b0;
    end else begin
      irq_pri <= pend && !msi_en && (route == ROUTE_PRI);
      irq_alt <= pend && !msi_en && (route == ROUTE_ALT);
    end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      reg_rdata[REPLY_BIT]        = msk_reply;
      reg_rdata[DB_BIT]           = msk_db;
      reg_rdata[ROUTE_LSB +: 2]   = route;
    end else begin
      reg_rdata[REPLY_BIT]        = !queue_empty;
      reg_rdata[DB_BIT]           = db_st;
    end
  end

endmodule

module host_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_sel,
  input logic       reg_wr,
  input logic       queue_empty,
  input logic       db_write,
  input logic       msi_en,
  input logic       irq_pri,
  input logic       irq_alt,
  input logic       db_st,
  input logic       msk_reply,
  input logic [1:0] route
);

  // R2
  db_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_write |=> db_st);

  // R3
  db_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && !db_write) |=> !db_st);

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (db_write && reg_wr && !reg_sel) |=> db_st);

  // R5
  reply_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!queue_empty && !msk_reply && !msi_en && route == 2'b00) |=> irq_pri);

  // R6
  pins_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_pri, irq_alt}));

  // R6
  route_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route[1] |=> (!irq_pri && !irq_alt));

  // R7
  msi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |=> (!irq_pri && !irq_alt));

endmodule

bind host_irq_ctrl host_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .queue_empty(queue_empty), .db_write(db_write), .msi_en(msi_en),
  .irq_pri(irq_pri), .irq_alt(irq_alt), .db_st(db_st),
  .msk_reply(msk_reply), .route(route)
);

// File: tb/test_host_irq_ctrl.sv
module test_host_irq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        reg_sel = 0, reg_wr = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        queue_empty = 1, db_write = 0, msi_en = 0;
  logic        irq_pri, irq_alt;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  host_irq_ctrl i_host_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .queue_empty(queue_empty),
    .db_write(db_write), .msi_en(msi_en), .irq_pri(irq_pri), .irq_alt(irq_alt)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1;
    tick();
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(logic sel, output logic [31:0] d);
    reg_sel = sel; #1 d = reg_rdata;
  endtask

  task automatic pins(string req, logic p, logic a);
    chk(req, {30'd0, irq_pri, irq_alt}, {30'd0, p, a});
  endtask

  task automatic ring();
    db_write = 1; tick(); db_write = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(1, d); chk("R8 mask reset", d, 32'h9);
    rd(0, d); chk("R8 status reset", d, 32'h0);
    pins("R8 pins reset", 0, 0);
    queue_empty = 0; ring(); tick(); tick();
    pins("R8 masked causes quiet", 0, 0);
    wr(0, 32'h0); queue_empty = 1; tick();
  endtask

  task automatic t_reply();
    logic [31:0] d;
    wr(1, 32'h1); tick();
    queue_empty = 0; rd(0, d); chk("R1 reply bit follows level", d, 32'h8);
    pins("R10 pin not yet", 0, 0);
    tick(); pins("R5 reply interrupt", 1, 0);
    queue_empty = 1; rd(0, d); chk("R1 reply bit drops", d, 32'h0);
    tick(); pins("R1 pin drops with level", 0, 0);
  endtask

  task automatic t_doorbell();
    logic [31:0] d;
    wr(1, 32'h8); tick();
    ring(); rd(0, d); chk("R2 doorbell set", d, 32'h1);
    pins("R10 doorbell pin delayed", 0, 0);
    tick(); pins("R5 doorbell interrupt", 1, 0);
    tick(); tick(); rd(0, d); chk("R2 doorbell holds", d, 32'h1);
    wr(0, 32'hDEAD_BEEF); rd(0, d); chk("R3 clear with nonzero data", d, 32'h0);
    tick(); pins("R3 pin off after clear", 0, 0);
    ring(); wr(0, 32'h0); rd(0, d); chk("R3 clear with zero data", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    reg_sel = 0; reg_wdata = 32'h1; reg_wr = 1; db_write = 1;
    tick();
    reg_wr = 0; db_write = 0;
    rd(0, d); chk("R4 set wins", d, 32'h1);
  endtask

  task automatic t_route();
    wr(1, 32'h108); tick(); pins("R6 route alternate", 0, 1);
    wr(1, 32'h208); tick(); pins("R6 route 10 none", 0, 0);
    wr(1, 32'h308); tick(); pins("R6 route 11 none", 0, 0);
    wr(1, 32'h009); tick(); pins("R5 masked doorbell", 0, 0);
    wr(1, 32'h008); tick(); pins("R6 route primary", 1, 0);
  endtask

  task automatic t_msi();
    msi_en = 1; tick(); pins("R7 msi suppresses", 0, 0);
    wr(1, 32'h108); tick(); pins("R7 msi suppresses alt", 0, 0);
    msi_en = 0; tick(); pins("R7 msi released", 0, 1);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    queue_empty = 0;
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R9 mask writable bits", d, 32'h309);
    rd(0, d); chk("R9 status other bits zero", d, 32'h9);
    wr(1, 32'hFFFF_FCF6); rd(1, d); chk("R9 mask reserved ignored", d, 32'h0);
    queue_empty = 1; wr(0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset();
    t_reply();
    t_doorbell();
    t_collide();
    t_route();
    t_msi();
    t_reserved();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule